// File: doc/BRIEF.md
# Control-Word Register-Transfer Datapath

This block is a 32-bit execution datapath with no sequencing of its own. On each clock a packed control word from an outside controller picks two source operands and an ALU function. It also picks where the result goes: a register, a memory word, or both. The block holds an eight-entry register file with two read ports and one write port, a function-select ALU with a one-bit shifter, and a word memory that reads combinationally.

Operand bus A carries either a register or an external address. It feeds the ALU's A input and addresses the memory. Operand bus B carries either a register or an external constant. It feeds the ALU's B input and is the memory write data. The result bus carries either the ALU output or the memory read data back to the register file. Each micro-operation finishes in one cycle. The memory depth is a parameter: a small default, and 16 address bits for the full 64K-word space.

Top module: `cw_datapath`

## Requirements
- R1: The 19-bit control word is packed, MSB first, as: A-register select [18:16], B-register select [15:13], destination select [12:10], A-source bit [9], B-source bit [8], function code [7:3], result-source bit [2], register write enable [1], memory write enable [0].
- R2: Bus A, visible on `addr_o`, carries `addr_i` when bit 9 is 1 and otherwise the register chosen by bits [18:16].
- R3: Bus B, visible on `data_o`, carries `const_i` when bit 8 is 1 and otherwise the register chosen by bits [15:13].
- R4: Arithmetic codes (function bits [4:3] = 00), with A and B the bus values: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00011 gives A+B+1, 00100 gives A+~B, 00101 gives A+~B+1 (A−B), 00110 gives A−1, and 00111 gives A with a carry.
- R5: Logic codes: 0100x gives A OR B, 0101x gives A AND B, 0110x gives A XOR B, and 0111x gives NOT A.
- R6: Codes 100xx pass B unchanged.
- R7: Shift codes act on B by one bit. 1010x is a logical right shift with 0 fill. 1011x is an arithmetic right shift that copies bit 31. 11xxx is a left shift with 0 fill.
- R8: N equals bit 31 of the ALU result, and Z is 1 when the ALU result is zero. For arithmetic codes, C is the adder carry-out and V is two's-complement overflow. For every other code, C and V are 0.
- R9: With bit 1 set, the result bus is stored in the destination register at the next rising edge. Reads in that same cycle still see the old value. With bit 1 clear, no register changes.
- R10: With bit 0 set, bus B is written at the rising edge into the memory word addressed by the low address bits of bus A. Memory reads are combinational. When bit 2 is 1, the result bus `bus_d_o` carries the memory word at bus A. Otherwise it carries the ALU result.
- R11: While `rst_ni` is low, every register and memory word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cw_i | input | 19 | Control word |
| const_i | input | 32 | External constant for bus B |
| addr_i | input | 32 | External address for bus A |
| addr_o | output | 32 | Bus A value (memory address) |
| data_o | output | 32 | Bus B value (memory write data) |
| bus_d_o | output | 32 | Result bus value |
| flag_n_o | output | 1 | Negative status |
| flag_z_o | output | 1 | Zero status |
| flag_c_o | output | 1 | Carry status |
| flag_v_o | output | 1 | Overflow status |

## Verification
The buses, the result bus and the four flags settle combinationally in the same cycle the control word is applied, so the bench drives each word on the falling edge and samples 1 ns later. Register and memory writes land on the following rising edge. The bench updates its own register and memory model only after that edge, and it sees a written value only through a later word that selects the written register or word onto a bus. This ordering also covers the same-cycle read of a register being written, which must still show the old value.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FS_W = 5;

  typedef enum logic [1:0] {
    OPB_ZERO = 2'b00,
    OPB_B    = 2'b01,
    OPB_INV  = 2'b10,
    OPB_ONES = 2'b11
  } opb_sel_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_MOVSR = 2'b10,
    GRP_SHL   = 2'b11
  } fs_grp_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W     = 32,
  parameter int N     = 8,
  localparam int AW   = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] wa_i,
  input  logic          we_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  qa_o,
  output logic [W-1:0]  qb_o
);
  logic [N-1:0][W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i) regs_q[wa_i] <= wd_i;
  end

  // no bypass: same-cycle reads see the stored value
  assign qa_o = regs_q[ra_i];
  assign qb_o = regs_q[rb_i];

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa_i)] == $past(wd_i));
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int W     = 32,
  parameter int AW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wd_i;
  end

  assign rd_o = mem_q[addr_i];

  a_r10_mem_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wd_i));
  a_r10_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    f_o,
  output flags_t          flags_o
);
  fs_grp_e     grp;
  opb_sel_e    opb_sel;
  logic [W-1:0] opb;
  logic [W:0]   sum;
  logic         is_arith;

  assign grp      = fs_grp_e'(fs_i[4:3]);
  assign opb_sel  = opb_sel_e'(fs_i[2:1]);
  assign is_arith = (grp == GRP_ARITH);

  always_comb begin
    unique case (opb_sel)
      OPB_ZERO: opb = '0;
      OPB_B:    opb = b_i;
      OPB_INV:  opb = ~b_i;
      default:  opb = '1;
    endcase
    sum = {1'b0, a_i} + {1'b0, opb} + {{W{1'b0}}, fs_i[0]};
  end

  always_comb begin
    unique case (grp)
      GRP_ARITH: f_o = sum[W-1:0];
      GRP_LOGIC: begin
        unique case (fs_i[2:1])
          2'b00:   f_o = a_i | b_i;
          2'b01:   f_o = a_i & b_i;
          2'b10:   f_o = a_i ^ b_i;
          default: f_o = ~a_i;
        endcase
      end
      GRP_MOVSR: begin
        if (!fs_i[2])     f_o = b_i;
        else if (!fs_i[1]) f_o = {1'b0, b_i[W-1:1]};
        else              f_o = {b_i[W-1], b_i[W-1:1]};
      end
      default: f_o = {b_i[W-2:0], 1'b0};
    endcase
  end

  assign flags_o.n = f_o[W-1];
  assign flags_o.z = ~|f_o;
  assign flags_o.c = is_arith & sum[W];
  assign flags_o.v = is_arith & (a_i[W-1] == opb[W-1]) & (f_o[W-1] != a_i[W-1]);

  a_r8_sub_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i == 5'b00101 && a_i == b_i) |-> (flags_o.z && flags_o.c && !flags_o.v));
  a_r8_nonarith_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i[4:3] != 2'b00) |-> (!flags_o.c && !flags_o.v));
  a_r7_asr_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i[4:1] == 4'b1011) |-> (f_o[W-1] == b_i[W-1]));
  a_r7_shl_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i[4:3] == 2'b11) |-> !f_o[0]);
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import dp_pkg::*;
#(
  parameter int W      = 32,
  parameter int REG_N  = 8,
  parameter int MEM_AW = 8,
  localparam int RAW   = $clog2(REG_N),
  localparam int CW_W  = 3 * RAW + FS_W + 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW_W-1:0] cw_i,
  input  logic [W-1:0]    const_i,
  input  logic [W-1:0]    addr_i,
  output logic [W-1:0]    addr_o,
  output logic [W-1:0]    data_o,
  output logic [W-1:0]    bus_d_o,
  output logic            flag_n_o,
  output logic            flag_z_o,
  output logic            flag_c_o,
  output logic            flag_v_o
);
  localparam int MW_B  = 0;
  localparam int RW_B  = 1;
  localparam int DS_B  = 2;
  localparam int FS_LO = 3;
  localparam int BS_B  = FS_LO + FS_W;
  localparam int AS_B  = BS_B + 1;
  localparam int DA_LO = AS_B + 1;
  localparam int BA_LO = DA_LO + RAW;
  localparam int AA_LO = BA_LO + RAW;

  logic [RAW-1:0]  aa, ba, da;
  logic [FS_W-1:0] fs;
  logic [W-1:0]    reg_a, reg_b, bus_a, bus_b, bus_d, alu_f, mem_rd;
  flags_t          flags;

  assign aa = cw_i[AA_LO +: RAW];
  assign ba = cw_i[BA_LO +: RAW];
  assign da = cw_i[DA_LO +: RAW];
  assign fs = cw_i[FS_LO +: FS_W];

  assign bus_a = cw_i[AS_B] ? addr_i  : reg_a;
  assign bus_b = cw_i[BS_B] ? const_i : reg_b;
  assign bus_d = cw_i[DS_B] ? mem_rd  : alu_f;

  dp_regfile #(.W(W), .N(REG_N)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra_i(aa), .rb_i(ba), .wa_i(da),
    .we_i(cw_i[RW_B]), .wd_i(bus_d),
    .qa_o(reg_a), .qb_o(reg_b)
  );

  dp_alu #(.W(W)) u_alu (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fs_i(fs), .a_i(bus_a), .b_i(bus_b),
    .f_o(alu_f), .flags_o(flags)
  );

  dp_mem #(.W(W), .AW(MEM_AW)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_a[MEM_AW-1:0]), .we_i(cw_i[MW_B]),
    .wd_i(bus_b), .rd_o(mem_rd)
  );

  assign addr_o   = bus_a;
  assign data_o   = bus_b;
  assign bus_d_o  = bus_d;
  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_v_o = flags.v;
endmodule

// File: tb/cw_datapath_test.sv
module cw_datapath_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [18:0] cw_i = '0;
  logic [31:0] const_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] addr_o, data_o, bus_d_o;
  logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_reg [8];
  logic [31:0] m_mem [256];

  always #2 clk = ~clk;

  cw_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .cw_i(cw_i), .const_i(const_i),
    .addr_i(addr_i), .addr_o(addr_o), .data_o(data_o), .bus_d_o(bus_d_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o)
  );

  function automatic logic [18:0] mk(input int aa, input int ba, input int da,
      input bit as_s, input bit bs_s, input logic [4:0] fs,
      input bit ds_s, input bit rw, input bit mw);
    return {aa[2:0], ba[2:0], da[2:0], as_s, bs_s, fs, ds_s, rw, mw};
  endfunction

  // returns {n,z,c,v,f}
  function automatic logic [35:0] alu_ref(input logic [4:0] fs,
      input logic [31:0] a, input logic [31:0] b);
    logic [32:0] r;
    logic [31:0] f;
    logic c, v;
    c = 0; v = 0; f = 0;
    if (fs[4:3] == 2'b00) begin
      case (fs[2:0])
        3'b000: begin f = a; end
        3'b001: begin f = a + 1; c = (a == 32'hFFFF_FFFF); v = (a == 32'h7FFF_FFFF); end
        3'b010, 3'b011: begin
          r = {1'b0, a} + {1'b0, b} + {32'd0, fs[0]};
          f = r[31:0]; c = r[32]; v = (a[31] == b[31]) && (f[31] != a[31]);
        end
        3'b100, 3'b101: begin
          r = {1'b0, a} + {1'b0, ~b} + {32'd0, fs[0]};
          f = r[31:0]; c = r[32]; v = (a[31] != b[31]) && (f[31] != a[31]);
        end
        3'b110: begin f = a - 1; c = (a != 0); v = (a == 32'h8000_0000); end
        default: begin f = a; c = 1; end
      endcase
    end else if (fs[4:3] == 2'b01) begin
      case (fs[2:1])
        2'b00: f = a | b;
        2'b01: f = a & b;
        2'b10: f = a ^ b;
        default: f = ~a;
      endcase
    end else if (fs[4:2] == 3'b100) f = b;
    else if (fs[4:1] == 4'b1010) f = b >> 1;
    else if (fs[4:1] == 4'b1011) f = $signed(b) >>> 1;
    else f = b << 1;
    return {f[31], (f == 0), c, v, f};
  endfunction

  function automatic string tag_of(input logic [4:0] fs, input bit ds_s);
    if (ds_s) return "R10";
    if (fs[4:3] == 2'b00) return "R4";
    if (fs[4:3] == 2'b01) return "R5";
    if (fs[4:2] == 3'b100) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // apply one control word, check combinational outputs, advance model past the edge
  task automatic op(input logic [18:0] cw, input logic [31:0] k,
      input logic [31:0] ad);
    logic [31:0] ea, eb, ed;
    logic [35:0] r;
    @(negedge clk);
    cw_i = cw; const_i = k; addr_i = ad;
    #1;
    ea = cw[9] ? ad : m_reg[cw[18:16]];
    eb = cw[8] ? k : m_reg[cw[15:13]];
    r  = alu_ref(cw[7:3], ea, eb);
    ed = cw[2] ? m_mem[ea[7:0]] : r[31:0];
    chk("R2", addr_o, ea);
    chk("R3", data_o, eb);
    chk(tag_of(cw[7:3], cw[2]), bus_d_o, ed);
    chk("R8", {28'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'd0, r[35:32]});
    @(posedge clk);
    if (cw[1]) m_reg[cw[12:10]] = ed;
    if (cw[0]) m_mem[ea[7:0]] = eb;
  endtask

  task automatic peek_reg(input int idx, input string tag, input logic [31:0] exp);
    @(negedge clk);
    cw_i = mk(idx, 0, 0, 0, 0, 5'b00000, 0, 0, 0);
    #1;
    chk(tag, addr_o, exp);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    // R11: cleared state, visible while still in reset and after release
    for (int i = 0; i < 8; i++) peek_reg(i, "R11", 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    // R1: load constant 5 into register 3 via field positions
    op(mk(0, 0, 3, 0, 1, 5'b10000, 0, 1, 0), 32'd5, 32'd0);
    peek_reg(3, "R1", 32'd5);
    // R9: same-cycle read of destination sees old value, new value next cycle
    op(mk(3, 0, 3, 0, 0, 5'b00001, 0, 1, 0), 32'd0, 32'd0);
    peek_reg(3, "R9", 32'd6);
    // R9: write enable low leaves register unchanged
    op(mk(0, 0, 3, 1, 1, 5'b10000, 0, 0, 0), 32'hDEAD_BEEF, 32'd0);
    peek_reg(3, "R9", 32'd6);
    // R10: memory write then read through result bus into register 2
    op(mk(0, 0, 0, 1, 1, 5'b00000, 0, 0, 1), 32'h0000_CAFE, 32'h20);
    op(mk(0, 0, 2, 1, 0, 5'b00000, 1, 1, 0), 32'd0, 32'h20);
    peek_reg(2, "R10", 32'h0000_CAFE);
    // R8 corners: subtract equal, overflow add, wrap increment
    op(mk(0, 0, 4, 1, 1, 5'b00101, 0, 1, 0), 32'h1234, 32'h1234);
    op(mk(0, 0, 4, 1, 1, 5'b00010, 0, 1, 0), 32'h0000_0001, 32'h7FFF_FFFF);
    op(mk(0, 0, 4, 1, 1, 5'b00001, 0, 1, 0), 32'd0, 32'hFFFF_FFFF);
    op(mk(0, 0, 4, 1, 1, 5'b00110, 0, 1, 0), 32'd0, 32'h8000_0000);
    // R7 corners: shifts of a sign-set pattern
    op(mk(0, 0, 5, 1, 1, 5'b10110, 0, 1, 0), 32'h80FF_0001, 32'd0);
    op(mk(0, 0, 5, 1, 1, 5'b10100, 0, 1, 0), 32'h80FF_0001, 32'd0);
    op(mk(0, 0, 5, 1, 1, 5'b11000, 0, 1, 0), 32'h80FF_0001, 32'd0);
    // R5/R6 directed
    op(mk(0, 0, 6, 1, 1, 5'b01110, 0, 1, 0), 32'h0F0F_0F0F, 32'h0000_FFFF);
    op(mk(0, 0, 6, 1, 1, 5'b10011, 0, 1, 0), 32'h0F0F_0F0F, 32'h0000_FFFF);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] k, ad;
      logic [18:0] cw;
      cw = 19'($urandom);
      k  = $urandom;
      ad = ($urandom % 4 == 0) ? {24'd0, 8'($urandom)} : $urandom;
      if (i % 7 == 0) k = 32'hFFFF_FFFF;
      op(cw, k, ad);
    end
    for (int i = 0; i < 8; i++) peek_reg(i, "R9", m_reg[i]);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule